// File: doc/BRIEF.md
# Window-Based PLL Lock Detector

This block decides whether a phase-locked loop is in lock by comparing the arrival of reference-clock rising edges with feedback-clock rising edges. Both clocks reach it as single-cycle edge strobes that have already been sampled into a fast detector clock. The detector measures how many detector cycles separate each reference/feedback edge pair. It accepts a pair as good when that distance does not exceed a programmable window.

After a programmable number of consecutive good pairs, the lock output goes high. A single pair outside the window clears it at once. So do two edges of the same clock with no edge of the other clock between them, which is taken as a frequency offset. An invalid feedback clock or a power-down request also clears the lock, the counter and the pair history in the same cycle.

Top module: `pll_lock_det`

## Requirements
- R1: `lock_o` rises in the cycle after the detector-clock edge that completes the N-th consecutive good pair, where N is `need_i`; a value of 0 in `need_i` behaves as 1.
- R2: A pair is good when the second strobe arrives at most `win_i` detector cycles after the first, in either order; strobes in the same cycle have distance 0.
- R3: When `win_i` cycles pass after a first strobe with no partner strobe, or when the partner arrives later than `win_i` cycles, `lock_o` is low in the cycle after that edge.
- R4: Two reference strobes with no feedback strobe between them, or two feedback strobes with no reference strobe between them, drop `lock_o` in the cycle after the second strobe. A same-cycle pair counts as both clocks having toggled.
- R5: Any miss sets the run of good pairs back to zero, so a fresh run of N good pairs is needed to lock again.
- R6: Once locked, further good pairs keep `lock_o` high; the run count saturates at its target and does not wrap.
- R7: While `fb_valid_i` is low, `lock_o` is low from the next cycle, the run count is cleared, and edge pairs have no effect.
- R8: While `pwr_dn_i` is high, `lock_o` is low from the next cycle. Pair tracking, offset history and the run count are cleared, and edge pairs have no effect.
- R9: After reset `lock_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Detector clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_edge_i | input | 1 | One-cycle strobe for each reference rising edge |
| fb_edge_i | input | 1 | One-cycle strobe for each feedback rising edge |
| fb_valid_i | input | 1 | Feedback clock judged present |
| pwr_dn_i | input | 1 | Power-down request, active high |
| win_i | input | WIN_W | Lock window in detector cycles |
| need_i | input | CNT_W | Consecutive good pairs required for lock |
| lock_o | output | 1 | Lock indication |

## Verification
The assertions assume that the edge strobes are single detector-cycle pulses. They also assume that `win_i` and `need_i` hold steady while a run of pairs is counted, so a rising lock can always be traced to a good pair in the cycle before. The stimulus changes the configuration only while power-down holds the block cleared. It drives each strobe for exactly one cycle and leaves idle gaps longer than the window between pairs. As a result, every outstanding first edge has either paired or timed out before the next pair starts.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
  typedef enum logic [1:0] {
    TRK_IDLE     = 2'd0,
    TRK_WAIT_FB  = 2'd1,
    TRK_WAIT_REF = 2'd2
  } trk_state_e;

  typedef enum logic [1:0] {
    LAST_NONE = 2'd0,
    LAST_REF  = 2'd1,
    LAST_FB   = 2'd2
  } last_edge_e;
endpackage

// File: rtl/lock_pair_track.sv
module lock_pair_track
  import pll_lock_pkg::*;
#(
  parameter int WIN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ref_edge_i,
  input  logic             fb_edge_i,
  input  logic [WIN_W-1:0] win_i,
  output logic             good_o,
  output logic             miss_o
);
  localparam logic [WIN_W-1:0] DIST_ONE = WIN_W'(1);

  trk_state_e       state_q, state_d;
  logic [WIN_W-1:0] dist_q, dist_d;

  always_comb begin
    state_d = state_q;
    dist_d  = dist_q;
    good_o  = 1'b0;
    miss_o  = 1'b0;
    unique case (state_q)
      TRK_IDLE: begin
        if (ref_edge_i && fb_edge_i) begin
          good_o = 1'b1;
        end else if (ref_edge_i) begin
          state_d = TRK_WAIT_FB;
          dist_d  = DIST_ONE;
        end else if (fb_edge_i) begin
          state_d = TRK_WAIT_REF;
          dist_d  = DIST_ONE;
        end
      end
      TRK_WAIT_FB: begin
        if (fb_edge_i) begin
          good_o  = (dist_q <= win_i);
          miss_o  = !(dist_q <= win_i);
          state_d = ref_edge_i ? TRK_WAIT_FB : TRK_IDLE;
          dist_d  = ref_edge_i ? DIST_ONE : '0;
        end else if (ref_edge_i) begin
          dist_d = DIST_ONE;  // restart; offset flagged by frequency monitor
        end else if (dist_q >= win_i) begin
          miss_o  = 1'b1;
          state_d = TRK_IDLE;
          dist_d  = '0;
        end else begin
          dist_d = dist_q + DIST_ONE;
        end
      end
      TRK_WAIT_REF: begin
        if (ref_edge_i) begin
          good_o  = (dist_q <= win_i);
          miss_o  = !(dist_q <= win_i);
          state_d = fb_edge_i ? TRK_WAIT_REF : TRK_IDLE;
          dist_d  = fb_edge_i ? DIST_ONE : '0;
        end else if (fb_edge_i) begin
          dist_d = DIST_ONE;
        end else if (dist_q >= win_i) begin
          miss_o  = 1'b1;
          state_d = TRK_IDLE;
          dist_d  = '0;
        end else begin
          dist_d = dist_q + DIST_ONE;
        end
      end
      default: begin
        state_d = TRK_IDLE;
        dist_d  = '0;
      end
    endcase
    if (clr_i) begin
      state_d = TRK_IDLE;
      dist_d  = '0;
      good_o  = 1'b0;
      miss_o  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TRK_IDLE;
      dist_q  <= '0;
    end else begin
      state_q <= state_d;
      dist_q  <= dist_d;
    end
  end
endmodule

// File: rtl/lock_freq_mon.sv
module lock_freq_mon
  import pll_lock_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic ref_edge_i,
  input  logic fb_edge_i,
  output logic offset_o
);
  last_edge_e last_q, last_d;
  logic       ref_only, fb_only;

  assign ref_only = ref_edge_i && !fb_edge_i;
  assign fb_only  = fb_edge_i && !ref_edge_i;

  always_comb begin
    last_d   = last_q;
    offset_o = 1'b0;
    if (ref_only) begin
      offset_o = (last_q == LAST_REF);
      last_d   = LAST_REF;
    end else if (fb_only) begin
      offset_o = (last_q == LAST_FB);
      last_d   = LAST_FB;
    end else if (ref_edge_i && fb_edge_i) begin
      last_d = LAST_NONE;
    end
    if (clr_i) begin
      last_d   = LAST_NONE;
      offset_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= LAST_NONE;
    else         last_q <= last_d;
  end
endmodule

// File: rtl/lock_run_cnt.sv
module lock_run_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             good_i,
  input  logic             miss_i,
  input  logic [CNT_W-1:0] need_i,
  output logic             lock_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, need_eff;
  logic             lock_q, lock_d;

  assign need_eff = (need_i == '0) ? CNT_W'(1) : need_i;

  always_comb begin
    cnt_d  = cnt_q;
    lock_d = lock_q;
    if (clr_i || miss_i) begin
      cnt_d  = '0;
      lock_d = 1'b0;
    end else if (good_i) begin
      if (cnt_q < need_eff) cnt_d = cnt_q + CNT_W'(1);
      if ({1'b0, cnt_q} + (CNT_W+1)'(1) >= {1'b0, need_eff}) lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/pll_lock_det.sv
module pll_lock_det #(
  parameter int WIN_W = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_edge_i,
  input  logic             fb_edge_i,
  input  logic             fb_valid_i,
  input  logic             pwr_dn_i,
  input  logic [WIN_W-1:0] win_i,
  input  logic [CNT_W-1:0] need_i,
  output logic             lock_o
);
  logic clr, pair_good, pair_miss, freq_off, any_miss;

  assign clr      = pwr_dn_i || !fb_valid_i;
  assign any_miss = pair_miss || freq_off;

  lock_pair_track #(.WIN_W(WIN_W)) i_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .ref_edge_i (ref_edge_i),
    .fb_edge_i  (fb_edge_i),
    .win_i      (win_i),
    .good_o     (pair_good),
    .miss_o     (pair_miss)
  );

  lock_freq_mon i_freq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .ref_edge_i (ref_edge_i),
    .fb_edge_i  (fb_edge_i),
    .offset_o   (freq_off)
  );

  lock_run_cnt #(.CNT_W(CNT_W)) i_run (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .good_i (pair_good),
    .miss_i (any_miss),
    .need_i (need_i),
    .lock_o (lock_o)
  );
endmodule

// File: rtl/pll_lock_det_chk.sv
module pll_lock_det_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic fb_valid_i,
  input logic pwr_dn_i,
  input logic pair_good,
  input logic pair_miss,
  input logic freq_off,
  input logic lock_o
);
  assert_pwr_dn_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_i |=> !lock_o);

  assert_fb_invalid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fb_valid_i |=> !lock_o);

  assert_window_miss_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_miss |=> !lock_o);

  assert_offset_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freq_off |=> !lock_o);

  assert_rise_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(pair_good));

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && !pair_miss && !freq_off && fb_valid_i && !pwr_dn_i) |=> lock_o);

  assert_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pair_good && pair_miss));
endmodule

bind pll_lock_det pll_lock_det_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fb_valid_i (fb_valid_i),
  .pwr_dn_i   (pwr_dn_i),
  .pair_good  (pair_good),
  .pair_miss  (pair_miss),
  .freq_off   (freq_off),
  .lock_o     (lock_o)
);

// File: tb/test_pll_lock_det.sv
module test_pll_lock_det;
  localparam int WIN_W = 4;
  localparam int CNT_W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             ref_edge_i = 1'b0;
  logic             fb_edge_i = 1'b0;
  logic             fb_valid_i = 1'b1;
  logic             pwr_dn_i = 1'b0;
  logic [WIN_W-1:0] win_i = 4'd3;
  logic [CNT_W-1:0] need_i = 8'd4;
  logic             lock_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pll_lock_det #(.WIN_W(WIN_W), .CNT_W(CNT_W)) i_pll_lock_det (
    .clk_i, .rst_ni, .ref_edge_i, .fb_edge_i, .fb_valid_i,
    .pwr_dn_i, .win_i, .need_i, .lock_o
  );

  task automatic chk(input logic exp, input string tag);
    checks++;
    if (lock_o !== exp) begin
      errors++;
      $display("FAIL %s lock_o actual %b expected %b", tag, lock_o, exp);
    end
  endtask

  // one detector cycle with the given strobes; returns at the next falling edge
  task automatic cyc(input logic r, input logic f);
    ref_edge_i = r;
    fb_edge_i  = f;
    @(negedge clk_i);
    ref_edge_i = 1'b0;
    fb_edge_i  = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0);
  endtask

  task automatic pair(input bit ref_first, input int d);
    if (d == 0) cyc(1'b1, 1'b1);
    else begin
      if (ref_first) cyc(1'b1, 1'b0); else cyc(1'b0, 1'b1);
      for (int i = 1; i < d; i++) cyc(1'b0, 1'b0);
      if (ref_first) cyc(1'b0, 1'b1); else cyc(1'b1, 1'b0);
    end
  endtask

  task automatic clear(input int w, input int n);
    pwr_dn_i = 1'b1;
    win_i    = WIN_W'(w);
    need_i   = CNT_W'(n);
    cyc(1'b0, 1'b0);
    pwr_dn_i = 1'b0;
    idle(2);
  endtask

  task automatic t_reset();
    chk(1'b0, "R9 reset");
  endtask

  task automatic t_lock_ref_first();
    clear(3, 4);
    pair(1, 2); chk(1'b0, "R1 after 1 pair"); idle(6);
    pair(1, 3); chk(1'b0, "R2 distance equals window"); idle(6);
    pair(1, 1); chk(1'b0, "R1 after 3 pairs"); idle(6);
    pair(1, 0); chk(1'b1, "R1 lock on 4th pair"); idle(6);
  endtask

  task automatic t_saturate();
    clear(3, 5);
    for (int i = 0; i < 5; i++) begin pair(1, 1); idle(6); end
    for (int i = 0; i < 12; i++) begin
      pair(1, 1); chk(1'b1, "R6 stays locked"); idle(6);
    end
  endtask

  task automatic t_window_miss();
    clear(3, 4);
    for (int i = 0; i < 4; i++) begin pair(1, 2); idle(6); end
    chk(1'b1, "R3 locked before miss");
    cyc(1'b1, 1'b0); idle(2);
    chk(1'b1, "R3 inside window");
    idle(1);
    chk(1'b0, "R3 timeout at window");
    cyc(1'b0, 1'b1); idle(6);
    for (int i = 0; i < 3; i++) begin
      pair(1, 1); chk(1'b0, "R5 run restarted"); idle(6);
    end
    pair(1, 1); chk(1'b1, "R5 relock after full run"); idle(6);
  endtask

  task automatic t_offset();
    clear(3, 4);
    for (int i = 0; i < 4; i++) begin pair(1, 1); idle(6); end
    cyc(1'b1, 1'b0); chk(1'b1, "R4 first ref");
    cyc(1'b1, 1'b0); chk(1'b0, "R4 second ref no fb");
    clear(3, 4);
    for (int i = 0; i < 4; i++) begin pair(0, 2); idle(6); end
    chk(1'b1, "R2 fb-first pairs lock");
    cyc(1'b0, 1'b1); chk(1'b1, "R4 first fb");
    cyc(1'b0, 1'b1); chk(1'b0, "R4 second fb no ref");
  endtask

  task automatic t_fb_invalid();
    clear(3, 4);
    for (int i = 0; i < 4; i++) begin pair(1, 1); idle(6); end
    fb_valid_i = 1'b0;
    cyc(1'b0, 1'b0); chk(1'b0, "R7 invalid drops lock");
    for (int i = 0; i < 5; i++) begin pair(1, 0); idle(3); end
    chk(1'b0, "R7 pairs ignored while invalid");
    fb_valid_i = 1'b1;
    for (int i = 0; i < 3; i++) begin pair(1, 0); idle(3); end
    chk(1'b0, "R7 count cleared");
    pair(1, 0); chk(1'b1, "R7 relock after valid");
  endtask

  task automatic t_pwr_dn();
    clear(3, 1);
    pair(1, 0); chk(1'b1, "R8 locked with need 1");
    pwr_dn_i = 1'b1;
    cyc(1'b0, 1'b0); chk(1'b0, "R8 power-down drops lock");
    pair(1, 0); chk(1'b0, "R8 pair ignored in power-down");
    cyc(1'b1, 1'b0);
    pwr_dn_i = 1'b0;
    cyc(1'b1, 1'b0); chk(1'b0, "R8 history cleared, ref opens wait");
    cyc(1'b0, 1'b1); chk(1'b1, "R8 no offset after clear");
  endtask

  task automatic t_window_zero();
    clear(0, 0);
    chk(1'b0, "R1 need 0 no lock without pair");
    pair(1, 1); chk(1'b0, "R3 distance 1 with window 0"); idle(4);
    pair(1, 0); chk(1'b1, "R1 need 0 acts as 1, R2 distance 0");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_lock_ref_first();
    t_saturate();
    t_window_miss();
    t_offset();
    t_fb_invalid();
    t_pwr_dn();
    t_window_zero();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule